// File: doc/BRIEF.md
# Serial Window-Offset Control Register

This block holds the signed offset word that tells a data-separator timing stage how far to move its detection window early or late of the nominal centre. Six bits arrive one at a time on a serial data line, each taken on a rising edge of a serial clock. A single enable line, normally the read gate, decides what happens. While it is low, serial bits shift into a staging register and the visible setting does not change. When it rises, shifting stops and the staged six bits are copied into a holding latch that drives the outputs.

The latched word gives a sign, a four-bit magnitude and a test-mode bit. The block also turns sign and magnitude into a five-bit two's-complement offset in the range -15 to +15. The serial clock, serial data and enable arrive asynchronously. They are brought into the system clock domain through synchronizer chains of parameterised depth, and every edge is detected in that domain.

In the wired-off configuration the serial data line is tied low and data pulses are used as the serial clock. In that setup the first rise of the enable line after power-up loads the nominal offset of zero.

Top module: `wstrobe_ctl`

## Requirements
- R1: After reset, `offsetWord` is 0, `offsetSigned` is 0 and `testMode` is 0.
- R2: While `regEn` is low, each rising edge of `serClk` shifts `serData` in MSB-first. After six edges, the first bit sent sits in staged bit 5, then sign in bit 4, then magnitude bits 3 down to 0. A rising `regEn` copies these into the latch.
- R3: While `regEn` stays low, shifting serial bits does not change `offsetWord`, `offsetSigned` or `testMode`.
- R4: `serClk` edges that occur while `regEn` is high are ignored. A later rise of `regEn` with no shifts in between reloads the same word.
- R5: With the default of two synchronizer stages, the latched outputs take the new word exactly three system-clock cycles after `regEn` rises, and not before.
- R6: `testMode` equals latched bit 5, which is the first serial bit of the load.
- R7: `offsetWord` is {sign, magnitude}. `offsetSigned` is the magnitude when the sign is 0 and its two's-complement negation when the sign is 1. For example, sign 1 with magnitude 15 gives 5'b10001 (-15).
- R8: Sign 1 with magnitude 0 decodes to `offsetSigned` = 0.
- R9: With `serData` held at 0, the first rise of `regEn` after reset loads offset 0 with test mode off, whether or not serial clock pulses came before it.
- R10: The shift strobe and the load strobe are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, latch and stage to zero |
| serClk | input | 1 | Serial shift clock (asynchronous) |
| serData | input | 1 | Serial data bit (asynchronous) |
| regEn | input | 1 | Register enable / read gate: low shifts, rising loads |
| offsetWord | output | 5 | Latched {sign, magnitude} |
| offsetSigned | output | 5 | Decoded two's-complement offset, -15..+15 |
| testMode | output | 1 | Latched test-mode bit |

## Verification
A staging register that shifts in the wrong order or on the wrong phase of `regEn` is only visible at the next rise of `regEn`. Three cycles after that rise, the latched outputs show a permuted or stale word. A latch that updates at the wrong time shows up while `regEn` stays low: `offsetWord` moves during a shift and breaks the hold expectation. A wrong decode is visible in the same cycle, as a mismatch between `offsetWord` and `offsetSigned` for signed words and for the negative-zero word.

// File: rtl/wstrobe_pkg.sv
package wstrobe_pkg;

  // Strobes from the sequencing logic to the datapath
  typedef struct packed {
    logic shiftEn;  // take serBit into the staging register
    logic loadEn;   // copy staging register into the latch
    logic enHeld;   // synchronized enable is high (shifting inhibited)
    logic serBit;   // synchronized serial data aligned with shiftEn
  } ctrlStb_t;

endpackage

// File: rtl/wstrobe_sync_ctl.sv
module wstrobe_sync_ctl
  import wstrobe_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     serClk,
  input  logic     serData,
  input  logic     regEn,
  output ctrlStb_t stb
);

  localparam int Last = SyncStages - 1;

  logic [SyncStages-1:0] clkSync;
  logic [SyncStages-1:0] datSync;
  logic [SyncStages-1:0] enSync;
  logic clkPrev;
  logic enPrev;

  generate
    if (SyncStages == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          clkSync <= '0;
          datSync <= '0;
          enSync  <= '0;
        end else begin
          clkSync <= serClk;
          datSync <= serData;
          enSync  <= regEn;
        end
      end
    end else begin : gChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          clkSync <= '0;
          datSync <= '0;
          enSync  <= '0;
        end else begin
          clkSync <= {clkSync[SyncStages-2:0], serClk};
          datSync <= {datSync[SyncStages-2:0], serData};
          enSync  <= {enSync[SyncStages-2:0], regEn};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      enPrev  <= 1'b0;
    end else begin
      clkPrev <= clkSync[Last];
      enPrev  <= enSync[Last];
    end
  end

  always_comb begin
    stb.enHeld  = enSync[Last];
    stb.serBit  = datSync[Last];
    stb.shiftEn = clkSync[Last] & ~clkPrev & ~enSync[Last];
    stb.loadEn  = enSync[Last] & ~enPrev;
  end

endmodule

// File: rtl/wstrobe_datapath.sv
module wstrobe_datapath
  import wstrobe_pkg::*;
#(
  parameter int MagBits  = 4,
  parameter int WordBits = MagBits + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStb_t            stb,
  output logic [WordBits-1:0] shiftStage,
  output logic [MagBits:0]    offsetWord,
  output logic                testMode,
  output logic [MagBits:0]    offsetSigned
);

  localparam int SignPos = MagBits;
  localparam int TestPos = MagBits + 1;

  logic [WordBits-1:0] stageQ;
  logic [WordBits-1:0] latchQ;
  logic [MagBits:0]    magExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '0;
    end else if (stb.shiftEn) begin
      stageQ <= {stageQ[WordBits-2:0], stb.serBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
    end else if (stb.loadEn) begin
      latchQ <= stageQ;
    end
  end

  always_comb begin
    magExt = {1'b0, latchQ[MagBits-1:0]};
    if (latchQ[SignPos]) begin
      offsetSigned = {(MagBits+1){1'b0}} - magExt;
    end else begin
      offsetSigned = magExt;
    end
  end

  assign shiftStage = stageQ;
  assign offsetWord = latchQ[SignPos:0];
  assign testMode   = latchQ[TestPos];

endmodule

// File: rtl/wstrobe_ctl.sv
module wstrobe_ctl
  import wstrobe_pkg::*;
#(
  parameter int MagBits    = 4,
  parameter int SyncStages = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           serClk,
  input  logic           serData,
  input  logic           regEn,
  output logic [MagBits:0] offsetWord,
  output logic [MagBits:0] offsetSigned,
  output logic           testMode
);

  localparam int WordBits = MagBits + 2;

  ctrlStb_t            stb;
  logic [WordBits-1:0] shiftStage;

  wstrobe_sync_ctl #(
    .SyncStages(SyncStages)
  ) ctl_i (
    .clk    (clk),
    .rstN   (rstN),
    .serClk (serClk),
    .serData(serData),
    .regEn  (regEn),
    .stb    (stb)
  );

  wstrobe_datapath #(
    .MagBits (MagBits),
    .WordBits(WordBits)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .shiftStage  (shiftStage),
    .offsetWord  (offsetWord),
    .testMode    (testMode),
    .offsetSigned(offsetSigned)
  );

endmodule

// File: rtl/wstrobe_ctl_chk.sv
module wstrobe_ctl_chk
  import wstrobe_pkg::*;
#(
  parameter int MagBits = 4
) (
  input logic               clk,
  input logic               rstN,
  input ctrlStb_t           stb,
  input logic [MagBits+1:0] shiftStage,
  input logic [MagBits:0]   offsetWord,
  input logic [MagBits:0]   offsetSigned,
  input logic               testMode
);

  // R2, R6: a load copies the staged word into the visible outputs
  a_r2_load_copies_stage: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadEn |=> ({testMode, offsetWord} == $past(shiftStage)));

  // R3: without a load strobe the visible setting holds
  a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadEn |=> ($stable(offsetWord) && $stable(testMode)));

  // R4: staging register frozen while enable is high
  a_r4_no_shift_when_enabled: assert property (@(posedge clk) disable iff (!rstN)
    stb.enHeld |=> $stable(shiftStage));

  // R7: positive words decode to their magnitude
  a_r7_positive_decode: assert property (@(posedge clk) disable iff (!rstN)
    !offsetWord[MagBits] |-> (offsetSigned == {1'b0, offsetWord[MagBits-1:0]}));

  // R7: negative words never decode above zero
  a_r7_negative_nonpositive: assert property (@(posedge clk) disable iff (!rstN)
    offsetWord[MagBits] |-> (offsetSigned[MagBits] || (offsetSigned == '0)));

  // R8: negative zero is zero
  a_r8_negative_zero: assert property (@(posedge clk) disable iff (!rstN)
    (offsetWord == {1'b1, {MagBits{1'b0}}}) |-> (offsetSigned == '0));

  // R10: shift and load are exclusive
  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.shiftEn, stb.loadEn}));

endmodule

bind wstrobe_ctl wstrobe_ctl_chk #(.MagBits(MagBits)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .stb         (stb),
  .shiftStage  (shiftStage),
  .offsetWord  (offsetWord),
  .offsetSigned(offsetSigned),
  .testMode    (testMode)
);

// File: tb/wstrobe_ctl_tb_top.sv
module wstrobe_ctl_tb_top;

  localparam int SyncStages = 2;
  localparam int LoadLat    = SyncStages + 1;

  typedef struct {
    logic [5:0] word;
    string      tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic regEn = 1'b0;
  logic [4:0] offsetWord;
  logic [4:0] offsetSigned;
  logic testMode;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  wstrobe_ctl #(.MagBits(4), .SyncStages(SyncStages)) dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .serClk      (serClk),
    .serData     (serData),
    .regEn       (regEn),
    .offsetWord  (offsetWord),
    .offsetSigned(offsetSigned),
    .testMode    (testMode)
  );

  function automatic int expSigned(input logic [5:0] w);
    int m;
    m = int'(w[3:0]);
    return w[4] ? -m : m;
  endfunction

  task automatic checkWord(input logic [5:0] w, input string tag);
    int got;
    total++;
    got = int'($signed(offsetSigned));
    if (testMode !== w[5] || offsetWord !== w[4:0] || got != expSigned(w)) begin
      bad++;
      $display("FAIL %s: got test=%b word=%b signed=%0d, expected test=%b word=%b signed=%0d",
               tag, testMode, offsetWord, got, w[5], w[4:0], expSigned(w));
    end
  endtask

  task automatic shiftBits(input logic [5:0] w, input int n);
    for (int i = 5; i > 5 - n; i--) begin
      serData = w[i];
      repeat (4) @(negedge clk);
      serClk = 1'b1;
      repeat (4) @(negedge clk);
      serClk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  // Driver: shift a word, raise enable, hand expectation to monitor
  task automatic loadWord(input logic [5:0] w, input string tag);
    @(negedge clk);
    regEn = 1'b0;
    repeat (4) @(negedge clk);
    shiftBits(w, 6);
    expQ.push_back('{word: w, tag: tag});
    regEn = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  // Monitor: compare once the load has had time to land
  initial begin
    forever begin
      wait (expQ.size() != 0);
      repeat (6) @(negedge clk);
      begin
        expItem_t it;
        it = expQ.pop_front();
        checkWord(it.word, it.tag);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkWord(6'b000000, "R1 in reset");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkWord(6'b000000, "R1 after reset");

    // R9: tied-low data, data pulses as clock, first enable rise
    serData = 1'b0;
    for (int k = 0; k < 3; k++) begin
      serClk = 1'b1; repeat (4) @(negedge clk);
      serClk = 1'b0; repeat (4) @(negedge clk);
    end
    expQ.push_back('{word: 6'b000000, tag: "R9 hardwired nominal"});
    regEn = 1'b1;
    repeat (12) @(negedge clk);

    loadWord(6'b001111, "R2 R7 +15");
    loadWord(6'b010101, "R2 R7 -5");
    loadWord(6'b011111, "R7 -15");
    loadWord(6'b010000, "R8 negative zero");
    loadWord(6'b100011, "R6 test bit +3");
    loadWord(6'b001010, "R2 +10");

    // R4: serial edges during enable high are ignored
    serData = 1'b1;
    for (int k = 0; k < 6; k++) begin
      serClk = 1'b1; repeat (4) @(negedge clk);
      serClk = 1'b0; repeat (4) @(negedge clk);
    end
    regEn = 1'b0;
    repeat (8) @(negedge clk);
    expQ.push_back('{word: 6'b001010, tag: "R4 reload unchanged"});
    regEn = 1'b1;
    repeat (12) @(negedge clk);

    // R3: partial shift with enable low leaves outputs alone
    regEn = 1'b0;
    repeat (4) @(negedge clk);
    shiftBits(6'b010110, 3);
    checkWord(6'b001010, "R3 hold mid-shift");
    for (int i = 2; i >= 0; i--) begin
      serData = 1'b0;
      if (i == 1) serData = 1'b1;
      repeat (4) @(negedge clk);
      serClk = 1'b1; repeat (4) @(negedge clk);
      serClk = 1'b0; repeat (4) @(negedge clk);
    end
    checkWord(6'b001010, "R3 hold full shift");

    // R5: exact latency, staged word is 010010 (-2)
    regEn = 1'b1;
    repeat (LoadLat - 1) @(negedge clk);
    checkWord(6'b001010, "R5 before latency");
    @(negedge clk);
    checkWord(6'b010010, "R5 at latency");
    repeat (12) @(negedge clk);

    loadWord(6'b000000, "R2 zero");

    wait (expQ.size() == 0);
    repeat (10) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule